// File: doc/BRIEF.md
# Sixteen-Bit Compare Timer with Forced Compare

The block is a 16-bit up-counter with two output-compare channels, A and B. On every cycle where the timer-clock enable is high, the counter advances and each channel compares its 16-bit compare value with the counter. A match raises that channel's flag and drives its waveform pin according to the channel's compare-output mode. Two counting modes exist. Normal mode wraps from 0xFFFF to 0 and raises an overflow flag. Clear-on-compare mode sends the counter back to zero on the tick after it equals compare A.

A processor reaches the counter and both compare values over an 8-bit register bus. All three share one temporary high-byte register, so that a 16-bit value always moves as a whole. A write to the counter closes a compare gate, which is a two-state machine. In state GATE_ARMED compares are live. A counter write moves it to GATE_HOLD (transition "counter written"). The next tick moves it back to GATE_ARMED (transition "tick consumed") without producing any match. A further counter write keeps it in GATE_HOLD.

Force strobes drive the waveform pins by the current mode. They never raise a flag and never clear the counter.

Top module: `tmr16_fc`

## Requirements
- R1: After reset the counter, both compare values, the control byte, all flags, the temporary byte and both waveform pins are zero.
- R2: A bus write to a high-byte address (0x29 counter, 0x27 compare A, 0x25 compare B) changes only the temporary byte. A write to the matching low address (0x28, 0x26, 0x24) loads the whole 16-bit register as {temporary byte, written byte} in one edge.
- R3: A read of a low address returns the live low half and copies that register's high half into the temporary byte. A read of any high address returns the temporary byte, which all three registers share.
- R4: Each cycle with `tick_en` high advances the counter by one; with `tick_en` low the counter holds.
- R5: In normal mode (control bit 4 = 0) a tick at 0xFFFF wraps the counter to 0 and sets the overflow flag.
- R6: In clear-on-compare mode (control bit 4 = 1) a live compare-A match on a tick sets the counter to 0 at that edge.
- R7: A live match sets its channel flag. The flag byte at 0x2C holds A in bit 0, B in bit 1 and overflow in bit 2, and writing a 1 to a bit clears it.
- R8: The control byte at 0x2A holds A's mode in bits 1:0 and B's in bits 3:2, coded 00 disconnected (pin holds), 01 toggle, 10 clear, 11 set. A match applies the mode to the pin.
- R9: After a counter write, the next tick produces no match on either channel. Matches resume on the tick after that.
- R10: Writing 0x2B with bit 7 (A) or bit 6 (B) set applies that channel's current mode to its pin. It sets no flag and leaves the counter unchanged.
- R11: Address 0x2B always reads as zero, and its bits 5:0 have no effect when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer-clock enable, one count per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (drives temporary-byte latching) |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| irq_a | output | 1 | Channel A compare flag |
| irq_b | output | 1 | Channel B compare flag |
| irq_ovf | output | 1 | Overflow flag |

## Verification
Read data is combinational, so the bench samples it at the falling edge inside the same cycle that the read strobe is high. A queued expected byte is compared there. Register writes, force strobes and ticks take effect at the next rising edge. The bench therefore changes inputs 1 ns after a rising edge and samples pins and readback only at a later falling edge. A run of n ticks is counted as exactly n rising edges with the enable high, and the first tick after any counter write is counted as a blocked one.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 3;

    typedef enum logic [1:0] {
        COM_OFF = 2'b00,
        COM_TOG = 2'b01,
        COM_CLR = 2'b10,
        COM_SET = 2'b11
    } com_e;

    typedef enum logic {
        GATE_ARMED = 1'b0,
        GATE_HOLD  = 1'b1
    } gate_e;

    localparam logic [ADDR_W-1:0] A_CNT_LO  = 6'h28;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 6'h29;
    localparam logic [ADDR_W-1:0] A_OCR0_LO = 6'h26;
    localparam logic [ADDR_W-1:0] A_CTRL    = 6'h2A;
    localparam logic [ADDR_W-1:0] A_FORCE   = 6'h2B;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 6'h2C;
endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic                          re_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [DATA_W-1:0]             rdata_o,
    input  logic [CNT_W-1:0]              cnt_i,
    input  logic [FLAG_W-1:0]             flags_i,
    output logic [NCH-1:0][CNT_W-1:0]     ocr_o,
    output logic [NCH-1:0][1:0]           com_o,
    output logic                          ctc_o,
    output logic [NCH-1:0]                force_o,
    output logic                          cnt_wr_o,
    output logic [CNT_W-1:0]              cnt_wr_val_o,
    output logic [FLAG_W-1:0]             flag_clr_o
);
    localparam int HI_W    = CNT_W - DATA_W;
    localparam int CTC_BIT = 2 * NCH;

    logic [HI_W-1:0]    temp_q;
    logic [CTC_BIT:0]   ctrl_q;
    logic [NCH-1:0]     ocr_lo_hit;
    logic [NCH-1:0]     ocr_hi_hit;
    logic               cnt_lo_hit;
    logic               cnt_hi_hit;
    logic               any_hi;
    logic               lo_rd_hit;
    logic [HI_W-1:0]    lo_rd_hi;

    assign cnt_lo_hit = (addr_i == A_CNT_LO);
    assign cnt_hi_hit = (addr_i == A_CNT_HI);
    assign any_hi     = cnt_hi_hit | (|ocr_hi_hit);

    // Per-channel compare registers, each pair of addresses two below the last
    for (genvar k = 0; k < NCH; k++) begin : g_ocr
        logic [CNT_W-1:0] ocr_q;
        assign ocr_lo_hit[k] = (addr_i == A_OCR0_LO - ADDR_W'(2 * k));
        assign ocr_hi_hit[k] = (addr_i == A_OCR0_LO - ADDR_W'(2 * k) + ADDR_W'(1));
        assign com_o[k]      = ctrl_q[2*k+1 -: 2];
        assign force_o[k]    = we_i && (addr_i == A_FORCE) && wdata_i[DATA_W-1-k];

        always_ff @(posedge clk) begin
            if (!rst_n)
                ocr_q <= '0;
            else if (we_i && ocr_lo_hit[k])
                ocr_q <= {temp_q, wdata_i};
        end
        assign ocr_o[k] = ocr_q;
    end

    assign ctc_o        = ctrl_q[CTC_BIT];
    assign cnt_wr_o     = we_i && cnt_lo_hit;
    assign cnt_wr_val_o = {temp_q, wdata_i};
    assign flag_clr_o   = (we_i && (addr_i == A_FLAGS)) ? wdata_i[FLAG_W-1:0] : '0;

    // High half captured by a low-byte read
    always_comb begin
        lo_rd_hit = cnt_lo_hit;
        lo_rd_hi  = cnt_i[CNT_W-1:DATA_W];
        for (int k = 0; k < NCH; k++) begin
            if (ocr_lo_hit[k]) begin
                lo_rd_hit = 1'b1;
                lo_rd_hi  = ocr_o[k][CNT_W-1:DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            temp_q <= '0;
        else if (we_i && any_hi)
            temp_q <= wdata_i[HI_W-1:0];
        else if (re_i && lo_rd_hit)
            temp_q <= lo_rd_hi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we_i && (addr_i == A_CTRL))
            ctrl_q <= wdata_i[CTC_BIT:0];
    end

    always_comb begin
        rdata_o = '0;
        if (cnt_lo_hit)
            rdata_o = cnt_i[DATA_W-1:0];
        if (any_hi)
            rdata_o = DATA_W'(temp_q);
        for (int k = 0; k < NCH; k++) begin
            if (ocr_lo_hit[k])
                rdata_o = ocr_o[k][DATA_W-1:0];
        end
        if (addr_i == A_CTRL)
            rdata_o = DATA_W'(ctrl_q);
        if (addr_i == A_FLAGS)
            rdata_o = DATA_W'(flags_i);
    end

    // R2: a low-byte write merges the temporary byte in one edge
    assert_lo_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && ocr_lo_hit[0]) |=> (ocr_o[0] == {$past(temp_q), $past(wdata_i)}));

    // R11: the strobe byte never reads back
    assert_force_rd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == A_FORCE) |-> (rdata_o == '0));
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_i,
    input  logic                      ctc_i,
    input  logic                      cnt_wr_i,
    input  logic [CNT_W-1:0]          cnt_wr_val_i,
    input  logic [NCH-1:0][CNT_W-1:0] ocr_i,
    input  logic                      ovf_clr_i,
    output logic [CNT_W-1:0]          cnt_o,
    output logic [NCH-1:0]            match_o,
    output logic                      ovf_o
);
    gate_e            gate_q;
    gate_e            gate_d;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             at_top;
    logic             ovf_set;

    // Compare gate: state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= GATE_ARMED;
        else
            gate_q <= gate_d;
    end

    // Compare gate: transitions
    always_comb begin
        gate_d = gate_q;
        unique case (gate_q)
            GATE_ARMED: if (cnt_wr_i) gate_d = GATE_HOLD;
            GATE_HOLD: begin
                if (cnt_wr_i)    gate_d = GATE_HOLD;
                else if (tick_i) gate_d = GATE_ARMED;
            end
        endcase
    end

    // Compare gate: outputs
    always_comb begin
        match_o = '0;
        unique case (gate_q)
            GATE_ARMED: begin
                for (int k = 0; k < NCH; k++)
                    match_o[k] = tick_i && !cnt_wr_i && (cnt_q == ocr_i[k]);
            end
            GATE_HOLD: match_o = '0;
        endcase
    end

    assign at_top  = (cnt_q == '1);
    assign ovf_set = tick_i && !cnt_wr_i && !ctc_i && at_top;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_wr_i)
            cnt_q <= cnt_wr_val_i;
        else if (tick_i) begin
            if (ctc_i && match_o[0])
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (ovf_set)
            ovf_q <= 1'b1;
        else if (ovf_clr_i)
            ovf_q <= 1'b0;
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    // R4: no tick and no write leaves the counter alone
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr_i) |=> $stable(cnt_q));

    // R5: normal-mode wrap raises overflow
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_wr_i && !ctc_i && (cnt_q == '1)) |=> ((cnt_q == '0) && ovf_q));

    // R6: clear-on-compare returns to zero
    assert_ctc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ctc_i && match_o[0]) |=> (cnt_q == '0));

    // R9: the cycle after a counter write yields no match
    assert_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> (match_o == '0));
endmodule

// File: rtl/tmr16_chan.sv
module tmr16_chan
    import tmr16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] com_i,
    input  logic       match_i,
    input  logic       force_i,
    input  logic       clr_i,
    output logic       wave_o,
    output logic       flag_o
);
    logic wave_q;
    logic wave_d;
    logic flag_q;

    // One action per cycle, whether from a match, a strobe or both
    always_comb begin
        wave_d = wave_q;
        if (match_i || force_i) begin
            unique case (com_e'(com_i))
                COM_OFF: wave_d = wave_q;
                COM_TOG: wave_d = ~wave_q;
                COM_CLR: wave_d = 1'b0;
                COM_SET: wave_d = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            wave_q <= 1'b0;
        else
            wave_q <= wave_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (match_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign wave_o = wave_q;
    assign flag_o = flag_q;

    // R7: a match always leaves the flag raised
    assert_match_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> flag_o);

    // R8: disconnected mode keeps the pin
    assert_off_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (com_i == COM_OFF) |=> $stable(wave_o));

    // R10: a strobe alone never moves the flag
    assert_force_noflag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && !match_i && !clr_i) |=> (flag_o == $past(flag_o)));
endmodule

// File: rtl/tmr16_fc.sv
module tmr16_fc
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wave_a,
    output logic              wave_b,
    output logic              irq_a,
    output logic              irq_b,
    output logic              irq_ovf
);
    localparam int NCH = 2;

    logic [NCH-1:0][CNT_W-1:0] ocr;
    logic [NCH-1:0][1:0]       com;
    logic [NCH-1:0]            force_s;
    logic [NCH-1:0]            match;
    logic [NCH-1:0]            wave;
    logic [NCH-1:0]            flag;
    logic [FLAG_W-1:0]         flag_clr;
    logic [FLAG_W-1:0]         flags;
    logic [CNT_W-1:0]          cnt;
    logic [CNT_W-1:0]          cnt_wr_val;
    logic                      cnt_wr;
    logic                      ctc;
    logic                      ovf;

    assign flags = {ovf, flag[1], flag[0]};

    tmr16_regs #(.CNT_W(CNT_W), .NCH(NCH)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (bus_we),
        .re_i         (bus_re),
        .addr_i       (bus_addr),
        .wdata_i      (bus_wdata),
        .rdata_o      (bus_rdata),
        .cnt_i        (cnt),
        .flags_i      (flags),
        .ocr_o        (ocr),
        .com_o        (com),
        .ctc_o        (ctc),
        .force_o      (force_s),
        .cnt_wr_o     (cnt_wr),
        .cnt_wr_val_o (cnt_wr_val),
        .flag_clr_o   (flag_clr)
    );

    tmr16_core #(.CNT_W(CNT_W), .NCH(NCH)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_en),
        .ctc_i        (ctc),
        .cnt_wr_i     (cnt_wr),
        .cnt_wr_val_i (cnt_wr_val),
        .ocr_i        (ocr),
        .ovf_clr_i    (flag_clr[FLAG_W-1]),
        .cnt_o        (cnt),
        .match_o      (match),
        .ovf_o        (ovf)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        tmr16_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .com_i   (com[k]),
            .match_i (match[k]),
            .force_i (force_s[k]),
            .clr_i   (flag_clr[k]),
            .wave_o  (wave[k]),
            .flag_o  (flag[k])
        );
    end

    assign wave_a  = wave[0];
    assign wave_b  = wave[1];
    assign irq_a   = flag[0];
    assign irq_b   = flag[1];
    assign irq_ovf = ovf;
endmodule

// File: tb/test_tmr16_fc.sv
module test_tmr16_fc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wave_a, wave_b, irq_a, irq_b, irq_ovf;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [7:0] exp;
        logic [5:0] addr;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    tmr16_fc i_tmr16_fc (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wave_a(wave_a), .wave_b(wave_b),
        .irq_a(irq_a), .irq_b(irq_b), .irq_ovf(irq_ovf)
    );

    // Monitor: pops one expected byte per read cycle
    always @(negedge clk) begin
        exp_t e;
        if (bus_re === 1'b1) begin
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: read at %h with nothing expected, got %h exp none",
                         bus_addr, bus_rdata);
            end else begin
                e = sb.pop_front();
                if (bus_rdata !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: read %h got %h exp %h", e.tag, e.addr, bus_rdata, e.exp);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        exp_t x;
        x.exp = e; x.addr = a; x.tag = tag;
        sb.push_back(x);
        bus_re = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic run(input int n);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    // idx: 0 wave_a, 1 wave_b, 2 irq_a, 3 irq_b, 4 irq_ovf
    task automatic pin(input int idx, input logic e, input string tag);
        logic act;
        @(negedge clk);
        case (idx)
            0: act = wave_a;
            1: act = wave_b;
            2: act = irq_a;
            3: act = irq_b;
            default: act = irq_ovf;
        endcase
        n_tests++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: pin %0d got %b exp %b", tag, idx, act, e);
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(6'h28, 8'h00, "R1 cnt lo");
        rd(6'h29, 8'h00, "R1 cnt hi");
        rd(6'h26, 8'h00, "R1 ocrA lo");
        rd(6'h2C, 8'h00, "R1 flags");
        pin(0, 1'b0, "R1 wave_a");
        pin(1, 1'b0, "R1 wave_b");
        pin(4, 1'b0, "R1 irq_ovf");

        // R2 R3 atomic access through the shared temporary byte
        wr(6'h27, 8'h12); wr(6'h26, 8'h34);
        rd(6'h26, 8'h34, "R2 ocrA lo");
        rd(6'h27, 8'h12, "R3 ocrA hi latched");
        wr(6'h29, 8'h55); wr(6'h24, 8'h66);
        rd(6'h24, 8'h66, "R2 ocrB lo");
        rd(6'h25, 8'h55, "R3 ocrB hi via shared temp");
        rd(6'h26, 8'h34, "R3 ocrA lo");
        wr(6'h25, 8'h77);
        rd(6'h27, 8'h77, "R3 temp overwritten by hi write");
        rd(6'h24, 8'h66, "R2 ocrB unchanged by hi write");
        rd(6'h25, 8'h55, "R2 ocrB hi unchanged");

        // R4 counting and holding
        wr(6'h29, 8'h00); wr(6'h28, 8'h10);
        run(7);
        rd(6'h28, 8'h17, "R4 count 7 ticks");
        rd(6'h29, 8'h00, "R4 count hi");
        repeat (4) @(posedge clk); #1;
        rd(6'h28, 8'h17, "R4 hold without tick");

        // R6 R8 clear-on-compare with toggle
        wr(6'h27, 8'h00); wr(6'h26, 8'h05);
        wr(6'h2A, 8'h11);
        wr(6'h29, 8'h00); wr(6'h28, 8'h00);
        run(6);
        rd(6'h28, 8'h00, "R6 cleared at compare A");
        pin(0, 1'b1, "R8 toggle on match");
        pin(2, 1'b1, "R7 flag A set");
        run(6);
        rd(6'h28, 8'h00, "R6 second period");
        pin(0, 1'b0, "R8 toggle back");

        // R7 write-one-to-clear
        wr(6'h2C, 8'h01);
        pin(2, 1'b0, "R7 flag A cleared");
        rd(6'h2C, 8'h00, "R7 flags clear");

        // R10 forced compare
        wr(6'h29, 8'h00); wr(6'h28, 8'h05);
        wr(6'h2A, 8'h13);
        wr(6'h2B, 8'h80);
        pin(0, 1'b1, "R10 force set");
        pin(2, 1'b0, "R10 force no flag");
        rd(6'h28, 8'h05, "R10 force keeps counter");
        wr(6'h2A, 8'h12); wr(6'h2B, 8'h80);
        pin(0, 1'b0, "R10 force clear");
        wr(6'h2A, 8'h11); wr(6'h2B, 8'h80);
        pin(0, 1'b1, "R10 force toggle");
        wr(6'h2A, 8'h10); wr(6'h2B, 8'h80);
        pin(0, 1'b1, "R8 disconnected keeps pin");
        rd(6'h2C, 8'h00, "R10 no flags after strobes");

        // R11 reserved strobe bits
        wr(6'h2A, 8'h1C);
        wr(6'h2B, 8'h3F);
        pin(1, 1'b0, "R11 reserved bits ignored B");
        pin(0, 1'b1, "R11 reserved bits ignored A");
        rd(6'h2B, 8'h00, "R11 strobe reads zero");
        wr(6'h2B, 8'h40);
        pin(1, 1'b1, "R10 force B set");
        rd(6'h2B, 8'h00, "R11 strobe reads zero after B");

        // R9 counter write blocks the next tick's match
        wr(6'h2A, 8'h08);
        wr(6'h25, 8'h01); wr(6'h24, 8'h00);
        wr(6'h29, 8'h01); wr(6'h28, 8'h00);
        run(1);
        pin(1, 1'b1, "R9 blocked match leaves wave_b");
        rd(6'h2C, 8'h00, "R9 blocked match no flag");
        rd(6'h28, 8'h01, "R9 count lo");
        rd(6'h29, 8'h01, "R9 count hi");
        wr(6'h29, 8'h00); wr(6'h28, 8'hFF);
        run(2);
        pin(1, 1'b0, "R9 match after blocked tick");
        pin(3, 1'b1, "R7 flag B set");
        rd(6'h2C, 8'h02, "R7 flag B bit");

        // R5 normal-mode wrap
        wr(6'h2C, 8'h07);
        wr(6'h29, 8'hFF); wr(6'h28, 8'hFE);
        run(3);
        rd(6'h28, 8'h01, "R5 wrapped lo");
        rd(6'h29, 8'h00, "R5 wrapped hi");
        pin(4, 1'b1, "R5 overflow pin");
        rd(6'h2C, 8'h04, "R5 overflow bit");
        wr(6'h2C, 8'h04);
        rd(6'h2C, 8'h00, "R7 overflow cleared");

        @(posedge clk); #1;
        n_tests++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: got %0d pending exp 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule